// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block makes four independent pulse-width-modulated outputs for driving backlight LEDs. Software programs it through a small memory-mapped register bank. Writes take effect on a clock edge, and reads return data combinationally in the same cycle. For each channel, software sets a period length and a high-time length, both counted in prescaled ticks. It also picks one of four clock prescale ratios and enables the channel. Once enabled, a channel's counter runs freely and its output is high for the first part of every period.

A separate output-mode register decides, channel by channel, whether the waveform reaches the pin or the pin is held low. New settings written while a channel runs wait for the end of the current period before they take effect, so the output never shows a shortened pulse. Software is expected to keep each duty value at or below its period value. The block still behaves in a defined way when a duty value is larger.

Top module: `pwm_bank`

## Requirements
- R1: There are four channels. Channel n drives `pwm_out[n]` on its own, and several channels can run at the same time with different settings.
- R2: The control register sits at offset 0x00. Bit n enables channel n. Bits [2n+5:2n+4] hold channel n's prescale code. A read returns these 12 bits, and bits 31..12 read as zero.
- R3: Channel n's configuration register sits at offset 0x04+4n. Bits [15:0] hold the period in ticks and bits [31:16] hold the duty in ticks. All 32 bits read back as written.
- R4: Prescale code 0 gives one tick per clock cycle. Code 1 gives one tick per 8 cycles, code 2 one tick per 64 cycles, and code 3 one tick per 512 cycles.
- R5: On the edge that enables a channel, its counter starts at 0. It advances once per tick and wraps after period-1. The output is high while the counter is below the duty value. A duty of 0 gives a constant low, and a duty at or above the period gives a constant high. A period of 0 or 1 holds the counter at 0.
- R6: Clearing a channel's enable bit drives its output low from the next cycle and resets its counter and prescaler. Enabling it again restarts the waveform from count 0.
- R7: A new period, duty or prescale code written while a channel runs leaves the current period unchanged. The new values apply from the tick that wraps the counter back to 0.
- R8: The output-mode register sits at offset 0x14 and has one bit per channel at bit 4n. A value of 0 passes the waveform to the pin, and a value of 1 holds the pin low. A read returns only bits 0, 4, 8 and 12.
- R9: A synchronous active-low reset clears every register, so all outputs are low after reset. Reads of offsets with no register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe; the write takes effect on the rising clock edge |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The waveform is swept over every duty from 0 to one above the period, for several short periods, under each of the four prescale codes. This shows apart the counter phase, the wrap point and the two saturating cases, duty 0 and duty at or above the period. Separate runs change the period, duty and prescale code in the middle of a period. These show whether the change waits for the wrap or leaks into the running period. Further patterns cover disabling and re-enabling a channel, the output-mode override, all four channels running at once, and register readback with unused bits and unmapped offsets.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int CNT_W       = 16;
  localparam int PSC_W       = 2;
  localparam int STAGE_W     = 3;
  localparam int STAGES      = (1 << PSC_W) - 1;
  localparam int CFG_W       = 2 * CNT_W;

  typedef struct packed {
    logic [CNT_W-1:0] duty;
    logic [CNT_W-1:0] period;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  output logic [NCH-1:0]              en_o,
  output logic [NCH-1:0][PSC_W-1:0]   code_o,
  output chan_cfg_t [NCH-1:0]         cfg_o,
  output logic [NCH-1:0]              off_o
);
  localparam int CODE_LSB    = 4;
  localparam int CFG_BASE_I  = 4;
  localparam int CFG_STRIDE  = 4;
  localparam int MODE_STRIDE = 4;
  localparam logic [AW-1:0] CTRL_ADDR = '0;
  localparam logic [AW-1:0] MODE_ADDR = AW'(CFG_BASE_I + CFG_STRIDE * NCH);
  localparam int CTRL_USED   = CODE_LSB + PSC_W * NCH;

  logic [NCH-1:0]            en_q;
  logic [NCH-1:0][PSC_W-1:0] code_q;
  chan_cfg_t [NCH-1:0]       cfg_q;
  logic [NCH-1:0]            off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      code_q <= '0;
      cfg_q  <= '0;
      off_q  <= '0;
    end else if (we) begin
      if (addr == CTRL_ADDR) begin
        for (int n = 0; n < NCH; n++) begin
          en_q[n]   <= wdata[n];
          code_q[n] <= wdata[CODE_LSB + PSC_W * n +: PSC_W];
        end
      end
      if (addr == MODE_ADDR) begin
        for (int n = 0; n < NCH; n++) off_q[n] <= wdata[MODE_STRIDE * n];
      end
      for (int n = 0; n < NCH; n++) begin
        if (addr == AW'(CFG_BASE_I + CFG_STRIDE * n))
          cfg_q[n] <= chan_cfg_t'(wdata[CFG_W-1:0]);
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) begin
      for (int n = 0; n < NCH; n++) begin
        rdata[n] = en_q[n];
        rdata[CODE_LSB + PSC_W * n +: PSC_W] = code_q[n];
      end
    end
    if (addr == MODE_ADDR) begin
      for (int n = 0; n < NCH; n++) rdata[MODE_STRIDE * n] = off_q[n];
    end
    for (int n = 0; n < NCH; n++) begin
      if (addr == AW'(CFG_BASE_I + CFG_STRIDE * n)) rdata[CFG_W-1:0] = cfg_q[n];
    end
  end

  assign en_o   = en_q;
  assign code_o = code_q;
  assign cfg_o  = cfg_q;
  assign off_o  = off_q;

  // R2: control reads never show bits beyond the used fields
  a_r2_ctrl_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == CTRL_ADDR) |-> (rdata[DW-1:CTRL_USED] == '0));

  // R9: registers are clear on the cycle after a reset cycle
  a_r9_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && off_q == '0 && cfg_q == '0));
endmodule

// File: rtl/pwm_bank_presc.sv
module pwm_bank_presc
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  logic [STAGES:0] carry;
  logic [STAGES-1:0][STAGE_W-1:0] q;

  assign carry[0] = 1'b1;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign carry[s+1] = carry[s] && (q[s] == {STAGE_W{1'b1}});
    always_ff @(posedge clk) begin
      if (!rst_n || !run || restart) q[s] <= '0;
      else if (carry[s])             q[s] <= q[s] + 1'b1;
    end
  end

  assign tick = run && carry[code];

  // R4: with any divide ratio above one, ticks never come on consecutive cycles
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != '0) |=> (!tick || code == '0));
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PSC_W-1:0] code_i,
  input  chan_cfg_t        cfg_i,
  output logic             wave_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_period;
  logic [CNT_W-1:0] act_duty;
  logic [PSC_W-1:0] act_code;
  logic             tick;
  logic             last;
  logic             wrap;

  assign last = (act_period <= CNT_W'(1)) || (cnt == act_period - CNT_W'(1));
  assign wrap = tick && last;

  pwm_bank_presc u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_i),
    .restart (wrap),
    .code    (act_code),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      act_period <= '0;
      act_duty   <= '0;
      act_code   <= '0;
    end else if (!en_i || wrap) begin
      cnt        <= '0;
      act_period <= cfg_i.period;
      act_duty   <= cfg_i.duty;
      act_code   <= code_i;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign wave_o = en_i && (cnt < act_duty);

  // R5: the counter stays inside the active period
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (act_period > CNT_W'(1)) |-> (cnt < act_period));

  // R7: active settings only move on a wrap while running
  a_r7_hold_until_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && !$past(wrap)) |->
      ($stable(act_period) && $stable(act_duty) && $stable(act_code)));

  // R6: a disabled channel restarts from count zero
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt == '0));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  logic [NCH-1:0]            en;
  logic [NCH-1:0][PSC_W-1:0] code;
  chan_cfg_t [NCH-1:0]       cfg;
  logic [NCH-1:0]            off;
  logic [NCH-1:0]            wave;

  pwm_bank_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .en_o   (en),
    .code_o (code),
    .cfg_o  (cfg),
    .off_o  (off)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pwm_bank_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en[n]),
      .code_i (code[n]),
      .cfg_i  (cfg[n]),
      .wave_o (wave[n])
    );
    assign pwm_out[n] = wave[n] && !off[n];

    // R6: a disabled channel never drives its pin high
    a_r6_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en[n] |-> !pwm_out[n]);

    // R8: an override bit holds the pin low
    a_r8_override_low: assert property (@(posedge clk) disable iff (!rst_n)
      off[n] |-> !pwm_out[n]);
  end
endmodule

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwm_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge (write has landed)
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  function automatic bit exp_wave(int i, int t, int d, int r);
    int c;
    c = (t <= 1) ? 0 : (i / r) % t;
    return c < d;
  endfunction

  function automatic logic [7:0] cfg_addr(int ch);
    return 8'(4 + 4 * ch);
  endfunction

  function automatic logic [31:0] ctrl_word(int ch, int code, bit en);
    return (32'(code) << (4 + 2 * ch)) | (32'(en) << ch);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int tlist[5];
    int run_id;
    tlist = '{0, 1, 2, 3, 5};
    run_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk("R9 outputs after reset", 32'(pwm_out), 32'h0);
    rd_chk("R9 ctrl after reset", 8'h00, 32'h0);
    rd_chk("R9 cfg0 after reset", 8'h04, 32'h0);
    rd_chk("R9 mode after reset", 8'h14, 32'h0);

    // R2 R3 R8 R9: readback
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl readback masks unused", 8'h00, 32'h0000_0FFF);
    wr(8'h00, 32'h0);
    for (int ch = 0; ch < 4; ch++) begin
      wr(cfg_addr(ch), 32'hA5C3_0000 + 32'(ch * 17 + 3));
    end
    for (int ch = 0; ch < 4; ch++) begin
      rd_chk("R3 cfg readback", cfg_addr(ch), 32'hA5C3_0000 + 32'(ch * 17 + 3));
    end
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R8 mode readback", 8'h14, 32'h0000_1111);
    wr(8'h14, 32'h0);
    rd_chk("R9 unmapped offset reads zero", 8'h18, 32'h0);
    rd_chk("R9 unmapped offset reads zero", 8'h40, 32'h0);

    // R4 R5: sweep of code, period and duty
    for (int code = 0; code < 4; code++) begin
      for (int ti = 0; ti < 5; ti++) begin
        int t;
        int r;
        int len;
        int ch;
        t = tlist[ti];
        if (code >= 2 && (t < 2 || t > 3)) continue;
        r = 1 << (3 * code);
        for (int d = 0; d <= t + 1; d++) begin
          ch = run_id % 4;
          run_id++;
          len = r * ((t < 1) ? 1 : t) * 2 + 3;
          wr(8'h00, 32'h0);
          wr(cfg_addr(ch), (32'(d) << 16) | 32'(t));
          wr(8'h00, ctrl_word(ch, code, 1'b0));
          wr(8'h00, ctrl_word(ch, code, 1'b1));
          for (int i = 0; i < len; i++) begin
            chk($sformatf("R4 R5 code=%0d t=%0d d=%0d i=%0d", code, t, d, i),
                32'(pwm_out), 32'(exp_wave(i, t, d, r)) << ch);
            @(negedge clk);
          end
        end
      end
    end

    // R7: period/duty change mid period
    wr(8'h00, 32'h0);
    wr(cfg_addr(1), (32'd1 << 16) | 32'd4);
    wr(8'h00, ctrl_word(1, 0, 1'b1));
    for (int i = 0; i < 30; i++) begin
      bit e;
      e = (i < 8) ? exp_wave(i, 4, 1, 1) : exp_wave(i - 8, 6, 3, 1);
      chk($sformatf("R7 cfg update at wrap i=%0d", i), 32'(pwm_out), 32'(e) << 1);
      if (i == 5) wr(cfg_addr(1), (32'd3 << 16) | 32'd6);
      else @(negedge clk);
    end

    // R7: prescale code change mid period
    wr(8'h00, 32'h0);
    wr(cfg_addr(2), (32'd2 << 16) | 32'd4);
    wr(8'h00, ctrl_word(2, 0, 1'b1));
    for (int i = 0; i < 70; i++) begin
      bit e;
      e = (i < 4) ? exp_wave(i, 4, 2, 1) : exp_wave(i - 4, 4, 2, 8);
      chk($sformatf("R7 code update at wrap i=%0d", i), 32'(pwm_out), 32'(e) << 2);
      if (i == 1) wr(8'h00, ctrl_word(2, 1, 1'b1));
      else @(negedge clk);
    end

    // R6: disable then re-enable restarts at count 0
    wr(8'h00, 32'h0);
    wr(cfg_addr(3), (32'd3 << 16) | 32'd5);
    wr(8'h00, ctrl_word(3, 0, 1'b1));
    for (int i = 0; i < 7; i++) begin
      chk("R6 before disable", 32'(pwm_out), 32'(exp_wave(i, 5, 3, 1)) << 3);
      @(negedge clk);
    end
    wr(8'h00, 32'h0);
    for (int i = 0; i < 3; i++) begin
      chk("R6 low while disabled", 32'(pwm_out), 32'h0);
      @(negedge clk);
    end
    wr(8'h00, ctrl_word(3, 0, 1'b1));
    for (int i = 0; i < 12; i++) begin
      chk("R6 restart from zero", 32'(pwm_out), 32'(exp_wave(i, 5, 3, 1)) << 3);
      @(negedge clk);
    end

    // R8: override holds pin low, release restores waveform
    wr(8'h00, 32'h0);
    wr(cfg_addr(0), (32'd4 << 16) | 32'd4);
    wr(8'h00, ctrl_word(0, 0, 1'b1));
    chk("R8 routed high", 32'(pwm_out), 32'h1);
    wr(8'h14, 32'h0000_0001);
    chk("R8 overridden low", 32'(pwm_out), 32'h0);
    @(negedge clk);
    chk("R8 stays low", 32'(pwm_out), 32'h0);
    wr(8'h14, 32'h0000_0010);
    chk("R8 other channel bit has no effect on ch0", 32'(pwm_out), 32'h1);
    wr(8'h14, 32'h0);

    // R1: four channels concurrently
    wr(8'h00, 32'h0);
    wr(cfg_addr(0), (32'd1 << 16) | 32'd3);
    wr(cfg_addr(1), (32'd2 << 16) | 32'd5);
    wr(cfg_addr(2), (32'd3 << 16) | 32'd4);
    wr(cfg_addr(3), (32'd1 << 16) | 32'd2);
    wr(8'h00, ctrl_word(3, 1, 1'b0));
    wr(8'h00, ctrl_word(3, 1, 1'b1) | 32'h7);
    for (int i = 0; i < 100; i++) begin
      logic [3:0] e;
      e[0] = exp_wave(i, 3, 1, 1);
      e[1] = exp_wave(i, 5, 2, 1);
      e[2] = exp_wave(i, 4, 3, 1);
      e[3] = exp_wave(i, 2, 1, 8);
      chk($sformatf("R1 concurrent i=%0d", i), 32'(pwm_out), 32'(e));
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule